// File: doc/BRIEF.md
# I2C Bus Condition and Frame Error Monitor

This block listens to the two lines of an I2C bus through its own synchronisers and recognises the START, repeated START and STOP conditions. Between conditions it follows where the bus stands inside the current 9-slot frame, which holds eight address or data bits followed by an acknowledge slot. It keeps a flag that shows whether the bus is owned. A START or STOP that lands at a point in the frame where it is not allowed counts as a bus error.

On a bus error the monitor raises its interrupt flag, reports status code 0x00 and holds both lines low through its pull-down enables. A control write then clears the fault. That write must carry both the interrupt-clear and the stop-request bits. It releases both lines in the same cycle, so the monitor drives no STOP sequence. The stop-request bit clears itself, and the monitor goes back to the unaddressed state. While the interrupt flag is clear, the status reads 0xF8, which means no information is available. Clock generation, byte transfer and address matching live elsewhere.

Top module: `i2c_cond_monitor`

## Requirements
- R1: `scl_in` and `sda_in` pass through two reset-to-high flip-flops and then one more history register. A line change that is present at clock edge n produces a condition pulse that is high in the cycle after edge n+1. It is not visible after edge n.
- R2: `start_det` pulses for one cycle when SDA falls while SCL stays high. `stop_det` pulses for one cycle when SDA rises while SCL stays high.
- R3: `bit_pos` is the index of the current frame slot, 0 to 8, where 8 is the acknowledge slot. START and STOP set it to 0. While the bus is busy, it advances by one on each SCL falling edge that follows an SCL rise in that slot, and it wraps from 8 to 0.
- R4: `bus_busy` goes to 1 on START or repeated START and goes to 0 on STOP.
- R5: A START or STOP seen while `bus_busy` is 1 and `bit_pos` is between 1 and 8 is a bus error. In the next cycle `int_flag` is 1 and `status` is 0x00.
- R6: A START or STOP while `bit_pos` is 0 (between bytes, or during the first clock of a byte), or while the bus is idle, raises no error.
- R7: While `int_flag` is 0, `status` reads 0xF8.
- R8: While a bus error is pending, `scl_pull` and `sda_pull` are 1 and `slave_unaddr` is 0.
- R9: A write with `wr_intclr`=1 and `wr_stop`=1 during a pending error has the following effect in the next cycle: `int_flag` is 0, both pulls drop together, `slave_unaddr` is 1 and `ctl_stop` is 0. `ctl_start` and `ctl_ack` take the written values. A new error in the same cycle wins over the recovery write.
- R10: During a pending error, a write with `wr_stop`=0 leaves `int_flag` set and `status` at 0x00.
- R11: Any write stores `wr_start` and `wr_ack`. Outside the recovery case it also stores `wr_stop`. With no error pending, `wr_intclr` has no effect.
- R12: After reset, `status` is 0xF8, `bit_pos` is 0, and `int_flag`, `bus_busy`, both pulls and all control bits are 0. `slave_unaddr` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| wr_en | input | 1 | Control write strobe |
| wr_start | input | 1 | Written start-request bit |
| wr_stop | input | 1 | Written stop-request bit |
| wr_ack | input | 1 | Written acknowledge-enable bit |
| wr_intclr | input | 1 | Written interrupt-clear bit |
| status | output | 8 | 0xF8 when no information, 0x00 on a bus error |
| int_flag | output | 1 | Interrupt flag |
| bus_busy | output | 1 | The bus is owned between START and STOP |
| bit_pos | output | 4 | Current frame slot, 0 to 8 |
| start_det | output | 1 | START or repeated START pulse |
| stop_det | output | 1 | STOP pulse |
| scl_pull | output | 1 | SCL pull-down enable |
| sda_pull | output | 1 | SDA pull-down enable |
| slave_unaddr | output | 1 | Monitor is in the unaddressed state |
| ctl_start | output | 1 | Stored start-request bit |
| ctl_stop | output | 1 | Stored stop-request bit |
| ctl_ack | output | 1 | Stored acknowledge-enable bit |

## Verification
Each frame begins with a START and then carries p complete bit clocks, for p from 0 to 8. It is then broken by a STOP or a repeated START placed during the next SCL high. This separates the legal slot 0 from the illegal slots 1 to 8, including the acknowledge slot. A two-byte transfer that ends in a STOP after the acknowledge slot checks that the wrap from 8 to 0 leaves a legal point. Writes during a fault, with and without the stop-request bit, separate a real recovery from an ignored clear. Writes with no fault pending show that the control bits are stored and the interrupt-clear bit does nothing.

// File: rtl/i2cmon_pkg.sv
package i2cmon_pkg;

  localparam int ACK_POS = 8;
  localparam int POS_W   = $clog2(ACK_POS + 1);

  localparam logic [7:0] STAT_NOINFO = 8'hF8;
  localparam logic [7:0] STAT_BUSERR = 8'h00;

  typedef enum logic {
    MON_UNADDR = 1'b0,
    MON_FAULT  = 1'b1
  } mon_state_e;

  typedef struct packed {
    logic start;
    logic stop;
    logic scl_rise;
    logic scl_fall;
  } bus_evt_t;

  // next slot index within a 9-slot frame
  function automatic logic [POS_W-1:0] pos_advance(input logic [POS_W-1:0] pos);
    if (pos == POS_W'(ACK_POS)) return '0;
    return pos + POS_W'(1);
  endfunction

  // a condition is illegal once any slot past slot 0 of a byte is in progress
  function automatic logic cond_illegal(input logic busy, input logic [POS_W-1:0] pos);
    return busy && (pos != '0);
  endfunction

  function automatic logic [7:0] status_code(input logic fault);
    return fault ? STAT_BUSERR : STAT_NOINFO;
  endfunction

endpackage

// File: rtl/i2cmon_sync.sv
module i2cmon_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic q_out
);

  logic [STAGES-1:0] chain;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= RST_VAL;
        else        chain[0] <= d_in;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= RST_VAL;
        else        chain[g] <= chain[g-1];
      end
    end
  end

  assign q_out = chain[STAGES-1];

endmodule

// File: rtl/i2cmon_cond_detect.sv
module i2cmon_cond_detect
  import i2cmon_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     scl_s,
  input  logic     sda_s,
  output bus_evt_t evt
);

  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  logic scl_held_high;
  assign scl_held_high = scl_p && scl_s;

  always_comb begin
    evt.start    = scl_held_high && sda_p && !sda_s;
    evt.stop     = scl_held_high && !sda_p && sda_s;
    evt.scl_rise = !scl_p && scl_s;
    evt.scl_fall = scl_p && !scl_s;
  end

  // R2
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt.start |=> !evt.start);

  // R2
  stop_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt.stop |=> !evt.stop);

endmodule

// File: rtl/i2cmon_frame_track.sv
module i2cmon_frame_track
  import i2cmon_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  bus_evt_t         evt,
  output logic             busy,
  output logic [POS_W-1:0] pos,
  output logic             err_evt
);

  logic             busy_q;
  logic [POS_W-1:0] pos_q;
  logic             clk_seen_q;

  assign err_evt = (evt.start || evt.stop) && cond_illegal(busy_q, pos_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      pos_q      <= '0;
      clk_seen_q <= 1'b0;
    end else if (evt.start) begin
      busy_q     <= 1'b1;
      pos_q      <= '0;
      clk_seen_q <= 1'b0;
    end else if (evt.stop) begin
      busy_q     <= 1'b0;
      pos_q      <= '0;
      clk_seen_q <= 1'b0;
    end else if (busy_q) begin
      if (evt.scl_rise) begin
        clk_seen_q <= 1'b1;
      end else if (evt.scl_fall && clk_seen_q) begin
        clk_seen_q <= 1'b0;
        pos_q      <= pos_advance(pos_q);
      end
    end
  end

  assign busy = busy_q;
  assign pos  = pos_q;

  // R3
  pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q <= POS_W'(ACK_POS));

  // R4
  busy_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt.start |=> (busy_q && pos_q == '0));

  // R4
  idle_on_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt.stop |=> !busy_q);

endmodule

// File: rtl/i2c_cond_monitor.sv
module i2c_cond_monitor
  import i2cmon_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_in,
  input  logic             sda_in,
  input  logic             wr_en,
  input  logic             wr_start,
  input  logic             wr_stop,
  input  logic             wr_ack,
  input  logic             wr_intclr,
  output logic [7:0]       status,
  output logic             int_flag,
  output logic             bus_busy,
  output logic [POS_W-1:0] bit_pos,
  output logic             start_det,
  output logic             stop_det,
  output logic             scl_pull,
  output logic             sda_pull,
  output logic             slave_unaddr,
  output logic             ctl_start,
  output logic             ctl_stop,
  output logic             ctl_ack
);

  logic scl_s, sda_s;

  i2cmon_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_scl (
    .clk(clk), .rst_n(rst_n), .d_in(scl_in), .q_out(scl_s)
  );

  i2cmon_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sda (
    .clk(clk), .rst_n(rst_n), .d_in(sda_in), .q_out(sda_s)
  );

  bus_evt_t evt;

  i2cmon_cond_detect u_detect (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s), .evt(evt)
  );

  logic             busy;
  logic [POS_W-1:0] pos;
  logic             err_evt;

  i2cmon_frame_track u_track (
    .clk(clk), .rst_n(rst_n), .evt(evt), .busy(busy), .pos(pos), .err_evt(err_evt)
  );

  mon_state_e state_q, state_d;
  logic       rec_cmd;
  logic       c_start_q, c_stop_q, c_ack_q;

  assign rec_cmd = wr_en && wr_intclr && wr_stop && (state_q == MON_FAULT) && !err_evt;

  always_comb begin
    state_d = state_q;
    if (err_evt)      state_d = MON_FAULT;
    else if (rec_cmd) state_d = MON_UNADDR;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= MON_UNADDR;
      c_start_q <= 1'b0;
      c_stop_q  <= 1'b0;
      c_ack_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (wr_en) begin
        c_start_q <= wr_start;
        c_ack_q   <= wr_ack;
        c_stop_q  <= rec_cmd ? 1'b0 : wr_stop;
      end
    end
  end

  assign int_flag     = (state_q == MON_FAULT);
  assign status       = status_code(int_flag);
  assign bus_busy     = busy;
  assign bit_pos      = pos;
  assign start_det    = evt.start;
  assign stop_det     = evt.stop;
  assign scl_pull     = int_flag;
  assign sda_pull     = int_flag;
  assign slave_unaddr = (state_q == MON_UNADDR);
  assign ctl_start    = c_start_q;
  assign ctl_stop     = c_stop_q;
  assign ctl_ack      = c_ack_q;

  // R5
  err_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt |=> (int_flag && status == STAT_BUSERR));

  // R7
  noinfo_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !int_flag |-> (status == STAT_NOINFO));

  // R9
  recover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_cmd |=> (!int_flag && !scl_pull && !sda_pull && !ctl_stop && slave_unaddr));

  // R10
  clear_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int_flag && wr_en && !wr_stop) |=> int_flag);

  // R8
  hold_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_flag) |-> (scl_pull && sda_pull && !slave_unaddr));

endmodule

// File: tb/i2c_cond_monitor_tb.sv
module i2c_cond_monitor_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_drv = 1'b1, sda_drv = 1'b1;
  logic wr_en = 1'b0, wr_start = 1'b0, wr_stop = 1'b0, wr_ack = 1'b0, wr_intclr = 1'b0;

  logic [7:0] status;
  logic       int_flag, bus_busy, start_det, stop_det, scl_pull, sda_pull, slave_unaddr;
  logic       ctl_start, ctl_stop, ctl_ack;
  logic [3:0] bit_pos;

  always #2.5 clk = ~clk;

  i2c_cond_monitor dut_i (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_drv), .sda_in(sda_drv),
    .wr_en(wr_en), .wr_start(wr_start), .wr_stop(wr_stop), .wr_ack(wr_ack),
    .wr_intclr(wr_intclr), .status(status), .int_flag(int_flag), .bus_busy(bus_busy),
    .bit_pos(bit_pos), .start_det(start_det), .stop_det(stop_det), .scl_pull(scl_pull),
    .sda_pull(sda_pull), .slave_unaddr(slave_unaddr), .ctl_start(ctl_start),
    .ctl_stop(ctl_stop), .ctl_ack(ctl_ack)
  );

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  bit q_scl[$] = '{1, 1, 1};
  bit q_sda[$] = '{1, 1, 1};
  int m_pos = 0;
  bit m_busy = 0, m_seen = 0, m_fault = 0;
  bit m_cs = 0, m_cst = 0, m_ca = 0;
  bit mvalid = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      q_scl = '{1, 1, 1};
      q_sda = '{1, 1, 1};
      m_pos = 0; m_busy = 0; m_seen = 0; m_fault = 0;
      m_cs = 0; m_cst = 0; m_ca = 0;
      mvalid = 1;
    end else begin
      bit hi, st, sp, rise, fall, bad, rec;
      hi   = q_scl[0] && q_scl[1];
      st   = hi && q_sda[0] && !q_sda[1];
      sp   = hi && !q_sda[0] && q_sda[1];
      rise = !q_scl[0] && q_scl[1];
      fall = q_scl[0] && !q_scl[1];
      bad  = (st || sp) && m_busy && (m_pos >= 1) && (m_pos <= 8);
      rec  = wr_en && wr_intclr && wr_stop && m_fault && !bad;
      if (wr_en) begin
        m_cs  = wr_start;
        m_ca  = wr_ack;
        m_cst = rec ? 1'b0 : wr_stop;
      end
      if (bad) m_fault = 1;
      else if (rec) m_fault = 0;
      if (st) begin m_busy = 1; m_pos = 0; m_seen = 0; end
      else if (sp) begin m_busy = 0; m_pos = 0; m_seen = 0; end
      else if (m_busy) begin
        if (rise) m_seen = 1;
        else if (fall && m_seen) begin
          m_seen = 0;
          m_pos = (m_pos + 1) % 9;
        end
      end
      q_scl.push_back(scl_drv); void'(q_scl.pop_front());
      q_sda.push_back(sda_drv); void'(q_sda.pop_front());
    end
  end

  always @(negedge clk) begin
    if (mvalid && rst_n && !done) begin
      bit e_st, e_sp;
      e_st = q_scl[0] && q_scl[1] && q_sda[0] && !q_sda[1];
      e_sp = q_scl[0] && q_scl[1] && !q_sda[0] && q_sda[1];
      check(start_det == e_st, "R2", "start_det", start_det, e_st);
      check(stop_det == e_sp, "R2", "stop_det", stop_det, e_sp);
      check(bit_pos == m_pos[3:0], "R3", "bit_pos", bit_pos, m_pos);
      check(bus_busy == m_busy, "R4", "bus_busy", bus_busy, m_busy);
      check(int_flag == m_fault, "R5", "int_flag", int_flag, m_fault);
      check(status == (m_fault ? 8'h00 : 8'hF8), "R7", "status", status, m_fault ? 8'h00 : 8'hF8);
      check(scl_pull == m_fault && sda_pull == m_fault, "R8", "pulls",
            {scl_pull, sda_pull}, {m_fault, m_fault});
      check(slave_unaddr == !m_fault, "R9", "slave_unaddr", slave_unaddr, !m_fault);
      check(ctl_stop == m_cst, "R9", "ctl_stop", ctl_stop, m_cst);
      check(ctl_start == m_cs && ctl_ack == m_ca, "R11", "ctl_start/ack",
            {ctl_start, ctl_ack}, {m_cs, m_ca});
    end
  end

  // ---------------- stimulus ----------------
  localparam int HOLD = 4;

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_drv = 1'b1; hold(HOLD);
    scl_drv = 1'b1; hold(HOLD);
    sda_drv = 1'b0; hold(HOLD);
    scl_drv = 1'b0; hold(HOLD);
  endtask

  task automatic bus_stop();
    scl_drv = 1'b0; sda_drv = 1'b0; hold(HOLD);
    scl_drv = 1'b1; hold(HOLD);
    sda_drv = 1'b1; hold(HOLD);
  endtask

  task automatic bit_clock(input bit val);
    sda_drv = val; hold(HOLD);
    scl_drv = 1'b1; hold(HOLD);
    scl_drv = 1'b0; hold(HOLD);
  endtask

  task automatic ctl_write(input bit s, input bit p, input bit a, input bit c);
    wr_en = 1'b1; wr_start = s; wr_stop = p; wr_ack = a; wr_intclr = c;
    hold(1);
    wr_en = 1'b0; wr_start = 1'b0; wr_stop = 1'b0; wr_ack = 1'b0; wr_intclr = 1'b0;
    hold(1);
  endtask

  // START, p full bit clocks, then a STOP or repeated START during the next SCL high
  task automatic inject(input int p, input bit as_stop);
    bit exp_err;
    exp_err = (p >= 1);
    bus_start();
    for (int i = 0; i < p; i++) bit_clock(i[0]);
    sda_drv = as_stop ? 1'b0 : 1'b1; hold(HOLD);
    scl_drv = 1'b1; hold(HOLD);
    sda_drv = as_stop ? 1'b1 : 1'b0; hold(HOLD);
    if (exp_err) begin
      check(int_flag == 1'b1, "R5", $sformatf("error flag at slot %0d", p), int_flag, 1);
      check(status == 8'h00, "R5", "error status", status, 8'h00);
      ctl_write(1'b0, 1'b0, 1'b1, 1'b1);
      check(int_flag == 1'b1 && status == 8'h00, "R10", "clear without stop request",
            {int_flag, status}, {1'b1, 8'h00});
      ctl_write(1'b1, 1'b1, 1'b0, 1'b1);
      check(int_flag == 1'b0 && status == 8'hF8, "R9", "recovery clears error",
            {int_flag, status}, {1'b0, 8'hF8});
      check(ctl_stop == 1'b0 && ctl_start == 1'b1 && ctl_ack == 1'b0, "R9",
            "recovery control bits", {ctl_start, ctl_stop, ctl_ack}, 3'b100);
      check(!scl_pull && !sda_pull && slave_unaddr, "R9", "lines released",
            {scl_pull, sda_pull, slave_unaddr}, 3'b001);
    end else begin
      check(int_flag == 1'b0, "R6", $sformatf("legal condition at slot %0d", p), int_flag, 0);
    end
    scl_drv = 1'b0; hold(HOLD);
    if (!as_stop || exp_err) bus_stop();
    check(bus_busy == 1'b0, "R4", "idle after stop", bus_busy, 0);
  endtask

  initial begin
    hold(3);
    check(status == 8'hF8, "R12", "reset status", status, 8'hF8);
    check({int_flag, bus_busy, scl_pull, sda_pull, ctl_start, ctl_stop, ctl_ack} == 7'b0,
          "R12", "reset flags",
          {int_flag, bus_busy, scl_pull, sda_pull, ctl_start, ctl_stop, ctl_ack}, 0);
    check(bit_pos == 4'd0 && slave_unaddr, "R12", "reset position", {bit_pos, slave_unaddr}, 1);
    rst_n = 1'b1;
    hold(4);

    // R1: synchroniser latency for a START
    scl_drv = 1'b1; sda_drv = 1'b0;
    hold(1);
    check(start_det == 1'b0, "R1", "start not yet visible", start_det, 0);
    hold(1);
    check(start_det == 1'b1, "R1", "start visible after sync", start_det, 1);
    hold(1);
    check(start_det == 1'b0, "R1", "start one cycle", start_det, 0);
    hold(HOLD);
    scl_drv = 1'b0; hold(HOLD);
    bus_stop();

    // R11: writes with no error pending
    ctl_write(1'b1, 1'b1, 1'b1, 1'b1);
    check(int_flag == 1'b0 && {ctl_start, ctl_stop, ctl_ack} == 3'b111, "R11",
          "write without error", {int_flag, ctl_start, ctl_stop, ctl_ack}, 4'b0111);
    ctl_write(1'b0, 1'b0, 1'b0, 1'b0);

    for (int p = 0; p <= 8; p++) inject(p, 1'b1);
    for (int p = 0; p <= 8; p++) inject(p, 1'b0);

    // R6: two full bytes with acknowledge, then a STOP between bytes
    bus_start();
    for (int i = 0; i < 18; i++) bit_clock(i[1]);
    check(bit_pos == 4'd0, "R3", "wrap after two frames", bit_pos, 0);
    bus_stop();
    check(int_flag == 1'b0, "R6", "stop after acknowledge", int_flag, 0);

    hold(4);
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule